// File: doc/BRIEF.md
# Residual Carrier Frequency Offset Estimator

This block measures the carrier frequency error that remains after coarse synchronisation. During a training frame, two frequency-domain OFDM training symbols are sent back to back under one fixed transmit/receive beamformer pair. Any phase that builds up between the two copies comes from the residual offset.

The block stores the first symbol's active subcarriers. As the second symbol streams in, it multiplies each stored sample by the conjugate of the matching new sample and sums the products. An iterative vectoring CORDIC then resolves the full four-quadrant angle of that sum. A single constant multiply turns the angle into a signed frequency word. The output is a one-cycle result strobe and a held offset word.

The estimator works only while the training enable is high. It runs alongside the channel estimation and weight computation. Applying the correction to the signal is handled elsewhere.

Top module: `ofe_cfo_est`

## Requirements
- R1: While reset is asserted and after it is released, `ofs_vld` is 0 and `ofs_hz` is 0 until the first result.
- R2: The result equals the angle of C = sum over k of s1[k]·conj(s2[k]), scaled by MULT/2^SHR. Here s1 is the first symbol and s2 the second, across NSC subcarriers. The angle is held as a 16-bit phase word in which 2^16 is one full turn. With the defaults (4 µs symbol spacing), one output LSB is 1 Hz and the result is accurate to within 60 LSB.
- R3: The angle covers all four quadrants. Phases in (π/2, π] and (−π, −π/2) come out with the correct sign, and the wrap at ±π maps to the ends of the output range (about ±125000 with the defaults).
- R4: `ofs_vld` is high for exactly one cycle. It rises on the ITER+2-th rising edge after the edge that captures the last sample of the second symbol.
- R5: When the sum C is exactly zero in both parts, the result is 0 and `ofs_vld` still pulses.
- R6: While `train_en` is low, the block returns to idle and produces no result. A pair interrupted this way never completes. Samples that arrive while idle, without a new `pair_start`, are ignored and leave `ofs_hz` unchanged.
- R7: `pair_start` with `train_en` high restarts collection from any state. If `sc_vld` is high in the same cycle, that sample is subcarrier 0 of the first symbol.
- R8: `ofs_hz` keeps its value in every cycle in which `ofs_vld` is low.
- R9: Only cycles with `sc_vld` high are counted. The first NSC counted samples form the first symbol and the next NSC form the second, in subcarrier order, so idle gaps between samples do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| train_en | input | 1 | High while a training frame is being received |
| pair_start | input | 1 | Marks the first subcarrier of the first symbol of a pair |
| sc_vld | input | 1 | Subcarrier sample strobe |
| sc_re | input | W | Real part of the post-FFT sample, signed |
| sc_im | input | W | Imaginary part of the post-FFT sample, signed |
| ofs_vld | output | 1 | One-cycle strobe marking a new estimate |
| ofs_hz | output | OW | Signed offset estimate, held between results |

## Verification
The assertions assume that `train_en` comes from a clean frame-level control, with its low cycles treated as aborts. They also assume that no sample arrives in the single launch cycle after the last compared sample. The bench meets both assumptions: it leaves at least one idle cycle after each second symbol, and it drops the enable only on purpose in the abort case. The accuracy limit in R2 assumes that each accumulated part stays within the accumulator width. The bench keeps every sample magnitude below 115, so the sum never comes close to that width. The test phases are placed a half step away from exact quadrant edges, and the offset is compared modulo one full turn, so rounding at ±π cannot cause a false miscompare.

// File: rtl/ofe_pkg.sv
package ofe_pkg;

  // Phase word: 2**PHW counts per full turn, wraps naturally.
  localparam int PHW = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_CMP,
    ST_LAUNCH,
    ST_SOLVE
  } ofe_state_e;

  // atan(2**-idx) expressed in phase-word counts (65536 per turn).
  function automatic logic [PHW-1:0] atan_step(input logic [3:0] idx);
    logic [PHW-1:0] v;
    case (idx)
      4'd0:  v = 16'd8192;
      4'd1:  v = 16'd4836;
      4'd2:  v = 16'd2555;
      4'd3:  v = 16'd1297;
      4'd4:  v = 16'd651;
      4'd5:  v = 16'd326;
      4'd6:  v = 16'd163;
      4'd7:  v = 16'd81;
      4'd8:  v = 16'd41;
      4'd9:  v = 16'd20;
      4'd10: v = 16'd10;
      4'd11: v = 16'd5;
      4'd12: v = 16'd3;
      4'd13: v = 16'd1;
      4'd14: v = 16'd1;
      4'd15: v = 16'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ofe_ref_store.sv
module ofe_ref_store #(
  parameter int W   = 8,
  parameter int NSC = 52,
  localparam int AW = $clog2(NSC)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic signed [W-1:0] wre,
  input  logic signed [W-1:0] wim,
  input  logic [AW-1:0]       raddr,
  output logic signed [W-1:0] rre,
  output logic signed [W-1:0] rim
);

  // Two lanes of the same storage, one per component.
  logic signed [W-1:0] lane_rd [2];
  logic signed [W-1:0] lane_wd [2];

  assign lane_wd[0] = wre;
  assign lane_wd[1] = wim;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [W-1:0] mem [NSC];

    always_ff @(posedge clk) begin
      if (we) begin
        mem[waddr] <= lane_wd[g];
      end
    end

    assign lane_rd[g] = mem[raddr];
  end

  assign rre = lane_rd[0];
  assign rim = lane_rd[1];

endmodule

// File: rtl/ofe_conj_mac.sv
module ofe_conj_mac #(
  parameter int W    = 8,
  parameter int ACCW = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  logic signed [W-1:0]    a_re,
  input  logic signed [W-1:0]    a_im,
  input  logic signed [W-1:0]    b_re,
  input  logic signed [W-1:0]    b_im,
  output logic signed [ACCW-1:0] acc_re,
  output logic signed [ACCW-1:0] acc_im
);

  localparam int PW  = 2 * W;
  localparam int SW  = PW + 1;

  logic signed [PW-1:0]   p_rr, p_ii, p_ir, p_ri;
  logic signed [SW-1:0]   t_re, t_im;
  logic signed [ACCW-1:0] acc_re_d, acc_im_d;

  // a * conj(b) = (ar*br + ai*bi) + j(ai*br - ar*bi)
  assign p_rr = a_re * b_re;
  assign p_ii = a_im * b_im;
  assign p_ir = a_im * b_re;
  assign p_ri = a_re * b_im;
  assign t_re = SW'(p_rr) + SW'(p_ii);
  assign t_im = SW'(p_ir) - SW'(p_ri);

  always_comb begin
    acc_re_d = acc_re;
    acc_im_d = acc_im;
    if (clr) begin
      acc_re_d = '0;
      acc_im_d = '0;
    end else if (en) begin
      acc_re_d = acc_re + ACCW'(t_re);
      acc_im_d = acc_im + ACCW'(t_im);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
    end else begin
      acc_re <= acc_re_d;
      acc_im <= acc_im_d;
    end
  end

  // R7: a restart leaves an empty sum for the new pair
  p_clear_on_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_re == '0 && acc_im == '0));

endmodule

// File: rtl/ofe_cordic_vec.sv
module ofe_cordic_vec
  import ofe_pkg::*;
#(
  parameter int ACCW = 23,
  parameter int ITER = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic signed [ACCW-1:0] x_in,
  input  logic signed [ACCW-1:0] y_in,
  output logic                   done,
  output logic [PHW-1:0]         angle
);

  localparam int CW = ACCW + 2;
  localparam int IW = $clog2(ITER) + 1;
  localparam logic [PHW-1:0] HALF_TURN = {1'b1, {(PHW-1){1'b0}}};

  logic signed [CW-1:0] x_q, y_q, x_d, y_d, xs, ys, xe, ye;
  logic [PHW-1:0]       z_q, z_d, step;
  logic [IW-1:0]        it_q, it_d;
  logic                 busy_q, busy_d, done_q, done_d, zero_q, zero_d;

  assign xe   = CW'(x_in);
  assign ye   = CW'(y_in);
  assign xs   = x_q >>> it_q;
  assign ys   = y_q >>> it_q;
  assign step = atan_step(4'(it_q));

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    z_d    = z_q;
    it_d   = it_q;
    busy_d = busy_q;
    zero_d = zero_q;
    done_d = 1'b0;
    if (start) begin
      zero_d = (x_in == '0) && (y_in == '0);
      if (x_in < 0) begin
        // fold left half-plane by half a turn
        x_d = -xe;
        y_d = -ye;
        z_d = HALF_TURN;
      end else begin
        x_d = xe;
        y_d = ye;
        z_d = '0;
      end
      it_d   = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (!y_q[CW-1]) begin
        x_d = x_q + ys;
        y_d = y_q - xs;
        z_d = z_q + step;
      end else begin
        x_d = x_q - ys;
        y_d = y_q + xs;
        z_d = z_q - step;
      end
      it_d = it_q + IW'(1);
      if (it_q == IW'(ITER - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      x_q    <= x_d;
      y_q    <= y_d;
      z_q    <= z_d;
      it_q   <= it_d;
      busy_q <= busy_d;
      done_q <= done_d;
      zero_q <= zero_d;
    end
  end

  assign done  = done_q;
  assign angle = zero_q ? '0 : z_q;

  // R4: completion only ever follows an iteration cycle
  p_done_follows_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));

  // R4: the iteration index never runs past the configured count
  p_iter_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (it_q < IW'(ITER)));

endmodule

// File: rtl/ofe_cfo_est.sv
module ofe_cfo_est
  import ofe_pkg::*;
#(
  parameter int W    = 8,
  parameter int NSC  = 52,
  parameter int ITER = 12,
  parameter int OW   = 18,
  parameter int MULT = 15625,
  parameter int SHR  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 train_en,
  input  logic                 pair_start,
  input  logic                 sc_vld,
  input  logic signed [W-1:0]  sc_re,
  input  logic signed [W-1:0]  sc_im,
  output logic                 ofs_vld,
  output logic signed [OW-1:0] ofs_hz
);

  localparam int AW   = $clog2(NSC);
  localparam int ACCW = 2 * W + 1 + $clog2(NSC);
  localparam int MW   = $clog2(MULT + 1) + 1;
  localparam int PRW  = PHW + MW;
  localparam logic [AW-1:0] LAST = AW'(NSC - 1);

  ofe_state_e st_q, st_d;
  logic [AW-1:0] cnt_q, cnt_d, wr_addr;
  logic          wr_en, mac_clr, mac_en, launch;
  logic          ofs_vld_d;
  logic signed [OW-1:0] ofs_d;

  logic signed [W-1:0]    ref_re, ref_im;
  logic signed [ACCW-1:0] acc_re, acc_im;
  logic                   ang_done;
  logic [PHW-1:0]         angle;
  logic signed [PRW-1:0]  ang_ext, mult_ext, prod, prod_sh;
  logic signed [OW-1:0]   scaled;

  ofe_ref_store #(.W(W), .NSC(NSC)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wre   (sc_re),
    .wim   (sc_im),
    .raddr (cnt_q),
    .rre   (ref_re),
    .rim   (ref_im)
  );

  ofe_conj_mac #(.W(W), .ACCW(ACCW)) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (mac_clr),
    .en     (mac_en),
    .a_re   (ref_re),
    .a_im   (ref_im),
    .b_re   (sc_re),
    .b_im   (sc_im),
    .acc_re (acc_re),
    .acc_im (acc_im)
  );

  ofe_cordic_vec #(.ACCW(ACCW), .ITER(ITER)) u_cordic (
    .clk   (clk),
    .rst_n (rst_n),
    .start (launch),
    .x_in  (acc_re),
    .y_in  (acc_im),
    .done  (ang_done),
    .angle (angle)
  );

  // phase word times 1/(2*pi*dt) expressed as MULT / 2**SHR
  assign ang_ext  = PRW'(signed'(angle));
  assign mult_ext = PRW'(MULT);
  assign prod     = ang_ext * mult_ext;
  assign prod_sh  = prod >>> SHR;
  assign scaled   = OW'(prod_sh);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    wr_en     = 1'b0;
    wr_addr   = cnt_q;
    mac_clr   = 1'b0;
    mac_en    = 1'b0;
    launch    = 1'b0;
    ofs_vld_d = 1'b0;
    ofs_d     = ofs_hz;
    if (!train_en) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (pair_start) begin
      mac_clr = 1'b1;
      st_d    = ST_REF;
      wr_addr = '0;
      if (sc_vld) begin
        wr_en = 1'b1;
        cnt_d = AW'(1);
      end else begin
        cnt_d = '0;
      end
    end else begin
      case (st_q)
        ST_REF: begin
          if (sc_vld) begin
            wr_en = 1'b1;
            if (cnt_q == LAST) begin
              cnt_d = '0;
              st_d  = ST_CMP;
            end else begin
              cnt_d = cnt_q + AW'(1);
            end
          end
        end
        ST_CMP: begin
          if (sc_vld) begin
            mac_en = 1'b1;
            if (cnt_q == LAST) begin
              cnt_d = '0;
              st_d  = ST_LAUNCH;
            end else begin
              cnt_d = cnt_q + AW'(1);
            end
          end
        end
        ST_LAUNCH: begin
          launch = 1'b1;
          st_d   = ST_SOLVE;
        end
        ST_SOLVE: begin
          if (ang_done) begin
            ofs_vld_d = 1'b1;
            ofs_d     = scaled;
            st_d      = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ofs_vld <= 1'b0;
      ofs_hz  <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ofs_vld <= ofs_vld_d;
      ofs_hz  <= ofs_d;
    end
  end

  // R4: the result strobe never lasts two cycles
  p_result_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_vld |=> !ofs_vld);

  // R8: the estimate is held while no result is flagged
  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_vld |-> $stable(ofs_hz));

  // R6: a dropped enable forces idle and suppresses any result
  p_off_no_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !train_en |=> (!ofs_vld && st_q == ST_IDLE));

  // R5: an empty correlation gives a zero estimate, still flagged
  p_zero_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SOLVE && ang_done && train_en && !pair_start &&
     acc_re == '0 && acc_im == '0) |=> (ofs_vld && ofs_hz == '0));

  // R9: the subcarrier index stays inside one symbol
  p_index_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: tb/tb_ofe_cfo_est.sv
module tb_ofe_cfo_est;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W    = 8;
  localparam int NSC  = 52;
  localparam int ITER = 12;
  localparam int OW   = 18;
  localparam int MULT = 15625;
  localparam int SHR  = 12;
  localparam real PI     = 3.14159265358979;
  localparam real FULL   = 65536.0 * MULT / (2.0 ** SHR);
  localparam real TOL_HZ = 60.0;

  logic clk, rst_n, train_en, pair_start, sc_vld;
  logic signed [W-1:0]  sc_re, sc_im;
  logic                 ofs_vld;
  logic signed [OW-1:0] ofs_hz;

  ofe_cfo_est #(.W(W), .NSC(NSC), .ITER(ITER), .OW(OW), .MULT(MULT), .SHR(SHR)) dut (
    .clk(clk), .rst_n(rst_n), .train_en(train_en), .pair_start(pair_start),
    .sc_vld(sc_vld), .sc_re(sc_re), .sc_im(sc_im), .ofs_vld(ofs_vld), .ofs_hz(ofs_hz)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 0;

  int r1re[NSC], r1im[NSC], r2re[NSC], r2im[NSC];

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, expv);
    end
  endtask

  task automatic drive(input int re, input int im, input bit st);
    @(negedge clk);
    sc_vld     = 1'b1;
    pair_start = st;
    sc_re      = W'(re);
    sc_im      = W'(im);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    sc_vld     = 1'b0;
    pair_start = 1'b0;
    sc_re      = 8'sh5a;
    sc_im      = -8'sh33;
  endtask

  task automatic fill(input real th, input int ar, input int ai, input int seed);
    real c, s;
    c = $cos(th);
    s = $sin(th);
    for (int k = 0; k < NSC; k++) begin
      int sg;
      sg = (((k * 37 + seed) % 11) < 5) ? -1 : 1;
      r1re[k] = sg * ar;
      r1im[k] = sg * ai;
      // s2 = s1 * exp(-j*th), so s1*conj(s2) has phase th
      r2re[k] = int'(r1re[k] * c + r1im[k] * s);
      r2im[k] = int'(r1im[k] * c - r1re[k] * s);
    end
  endtask

  task automatic expected(output bit zero, output real hz);
    longint sr, si;
    sr = 0;
    si = 0;
    for (int k = 0; k < NSC; k++) begin
      sr += longint'(r1re[k] * r2re[k] + r1im[k] * r2im[k]);
      si += longint'(r1im[k] * r2re[k] - r1re[k] * r2im[k]);
    end
    zero = (sr == 0) && (si == 0);
    if (zero) hz = 0.0;
    else hz = $atan2(real'(si), real'(sr)) / (2.0 * PI) * FULL;
  endtask

  // Send a full pair, then time and capture the result strobe.
  task automatic run_pair(input int gap, output bit seen, output int lat, output int got);
    for (int k = 0; k < 2 * NSC; k++) begin
      if (gap > 0 && k > 0 && (k % gap) == 0) idle_cycle();
      if (k < NSC) drive(r1re[k], r1im[k], k == 0);
      else drive(r2re[k-NSC], r2im[k-NSC], 1'b0);
    end
    idle_cycle();
    seen = 0;
    lat  = 0;
    got  = 0;
    for (int c = 0; c < 60; c++) begin
      if (ofs_vld) begin
        seen = 1;
        got  = int'(ofs_hz);
        break;
      end
      @(negedge clk);
      lat++;
    end
    if (seen) begin
      @(negedge clk);
      check(!ofs_vld, "R4", "strobe width", real'(ofs_vld), 0.0);
    end
  endtask

  task automatic check_value(input string req, input int got, input real hz);
    real d;
    d = real'(got) - hz;
    if (d > FULL / 2.0) d -= FULL;
    if (d < -FULL / 2.0) d += FULL;
    check((d <= TOL_HZ) && (d >= -TOL_HZ), req, "offset value", real'(got), hz);
  endtask

  task automatic full_case(input string req, input int gap);
    bit seen, zero;
    int lat, got;
    real hz;
    expected(zero, hz);
    run_pair(gap, seen, lat, got);
    check(seen, req, "result strobe seen", real'(seen), 1.0);
    check(lat == ITER + 2, "R4", "latency", real'(lat), real'(ITER + 2));
    if (zero) check(got == 0, "R5", "zero sum result", real'(got), 0.0);
    else check_value(req, got, hz);
    repeat (3) @(negedge clk);
    check(int'(ofs_hz) == got, "R8", "held value", real'(ofs_hz), real'(got));
  endtask

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    int lat, got, prev;
    rst_n = 1'b0; train_en = 1'b0; pair_start = 1'b0; sc_vld = 1'b0;
    sc_re = '0; sc_im = '0;
    repeat (4) @(negedge clk);
    check(!ofs_vld, "R1", "strobe in reset", real'(ofs_vld), 0.0);
    check(ofs_hz == '0, "R1", "offset in reset", real'(ofs_hz), 0.0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!ofs_vld && ofs_hz == '0, "R1", "state after release", real'(ofs_hz), 0.0);
    train_en = 1'b1;

    // R2 R3: sweep the whole circle, half a step off the quadrant edges
    for (int i = 0; i < 72; i++) begin
      real th;
      th = -PI + (real'(i) + 0.5) * 2.0 * PI / 72.0;
      fill(th, 20 + (i * 13) % 60, ((i * 7) % 50) - 25, i);
      full_case((th > PI / 2.0 || th < -PI / 2.0) ? "R3" : "R2", 0);
    end

    // R9: idle gaps between samples
    for (int g = 2; g <= 5; g++) begin
      fill(0.3 * g - 0.7, 45, -30, g);
      full_case("R9", g);
    end

    // R5: an all-zero correlation
    fill(1.0, 0, 0, 3);
    full_case("R5", 0);

    // R6: abort mid-pair by dropping the enable
    fill(1.1, 50, 20, 4);
    prev = int'(ofs_hz);
    for (int k = 0; k < 30; k++) drive(r1re[k], r1im[k], k == 0);
    @(negedge clk); sc_vld = 1'b0; pair_start = 1'b0; train_en = 1'b0;
    @(negedge clk); train_en = 1'b1;
    for (int k = 30; k < 2 * NSC; k++) begin
      if (k < NSC) drive(r1re[k], r1im[k], 1'b0);
      else drive(r2re[k-NSC], r2im[k-NSC], 1'b0);
    end
    idle_cycle();
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      if (ofs_vld) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R6", "no result after abort", real'(seen), 0.0);
    check(int'(ofs_hz) == prev, "R6", "offset untouched by abort", real'(ofs_hz), real'(prev));

    // R6: samples while idle are ignored
    for (int k = 0; k < 2 * NSC; k++) drive(r1re[k % NSC], r2im[k % NSC], 1'b0);
    idle_cycle();
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      if (ofs_vld) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R6", "no result from idle samples", real'(seen), 0.0);
    check(int'(ofs_hz) == prev, "R6", "offset untouched while idle", real'(ofs_hz), real'(prev));
    full_case("R6", 0);

    // R7: restart discards a partly collected pair
    fill(-2.0, 70, 10, 6);
    for (int k = 0; k < 50; k++) drive(r2re[k], r1re[k], k == 0);
    fill(2.2, 35, 40, 7);
    full_case("R7", 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule